// File: doc/BRIEF.md
# SD 4-bit read data block receiver

This block captures one read data block coming from a memory card over its four-wire data bus and turns it into a stream of bytes. Each bit time on the card bus is marked by a one-cycle clock-enable strobe from the card clock generator. The receiver only acts on cycles that carry a strobe. After it is armed, the receiver polls DAT0 once per strobe, looking for the low start bit. Once the start bit is found, it reads two nibbles per byte and issues each byte on a one-cycle valid pulse. It then lets the CRC and end-bit strobes pass without checking them, and reports the end of the block with a one-cycle pulse.

For a multi-block read the `multi` input is held high. The receiver then rearms itself after every block and hunts for the next start bit without a new `start`. If DAT0 stays high for the whole timeout window, the receiver raises a sticky timeout flag and goes back to idle without producing any byte.

The controller is a four-state machine:
- IDLE: waits for `start`.
- HUNT: polls DAT0 and runs the timeout.
- DATA: counts nibbles.
- TAIL: counts the discarded CRC/end strobes.

Its transitions are:
- IDLE to HUNT on `start`.
- HUNT to DATA on a low DAT0.
- HUNT to IDLE on timeout.
- DATA to TAIL after the last nibble.
- TAIL to HUNT when `multi` is high at the last tail strobe.
- TAIL to IDLE when `multi` is low at the last tail strobe.

Top module: `sd_blk_rx`

## Requirements
- R1: After reset `byte_vld`, `blk_done` and `timeout_flag` are low and the receiver is idle.
- R2: In idle, a rising `start` on any cycle arms the receiver. Without `start`, DAT activity produces no byte and no `blk_done`. A `start` given while a block is being received has no effect on the block or on what follows it.
- R3: While armed, the first strobe that sees DAT0 = 0 is the start bit. It is consumed and not stored, and the first data nibble is taken on the next strobe.
- R4: Each data strobe carries one nibble, with DAT3 as bit 3 and DAT0 as bit 0. The first nibble of a byte is bits 7:4 and the second is bits 3:0. `byte_vld` is high for one cycle, the cycle after the strobe of the second nibble, with the byte on `byte_data`.
- R5: A block yields exactly BLOCK_BYTES bytes, which is 2*BLOCK_BYTES data strobes.
- R6: After the last nibble, TAIL_CLKS strobes are discarded whatever DAT carries. `blk_done` is a one-cycle pulse in the cycle after the last of them.
- R7: TIMEOUT_CLKS consecutive armed strobes with DAT0 = 1 set `timeout_flag` in the cycle after the last one. The receiver then returns to idle with no byte emitted, and a start bit on the next strobe of the window (one fewer high strobe) is still accepted. The flag stays set until the next `start` clears it.
- R8: If `multi` is high at the last tail strobe, the receiver hunts for the next block without `start`. If it is low, the receiver goes idle.
- R9: Cycles without a strobe change nothing: no nibble, poll or tail count is taken on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_ce | input | 1 | One-cycle strobe marking one card bus bit time |
| start | input | 1 | Arms the receiver from idle |
| multi | input | 1 | High: rearm after each block |
| dat | input | 4 | Card data lines, DAT3 in bit 3 |
| byte_vld | output | 1 | One-cycle valid for `byte_data` |
| byte_data | output | 8 | Received byte |
| blk_done | output | 1 | One-cycle pulse at block end |
| timeout_flag | output | 1 | Sticky start-bit timeout indication |

## Verification
The bench builds the receiver with BLOCK_BYTES = 4, TAIL_CLKS = 5 and TIMEOUT_CLKS = 12. With these values a run of 64 back-to-back multi-block reads carries every one of the 256 byte values. The short timeout puts both edges of the window within reach: a start bit after 11 high polls, and expiry on the 12th. Strobe gaps inside the hunt and the data phase, and a stray `start` in the middle of a block, are mixed across the sweep.

// File: rtl/sd_blk_rx_pkg.sv
package sd_blk_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } rx_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/sd_blk_rx_cnt.sv
module sd_blk_rx_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sd_blk_rx_pack.sv
module sd_blk_rx_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       take,
    input  logic [3:0] nib,
    output logic       byte_vld,
    output logic [7:0] byte_data
);
    logic       phase;
    logic [3:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            hi_q      <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (clr) begin
                phase <= 1'b0;
            end else if (take) begin
                phase <= ~phase;
                if (!phase) begin
                    hi_q <= nib;
                end else begin
                    byte_vld  <= 1'b1;
                    byte_data <= {hi_q, nib};
                end
            end
        end
    end

    // R4
    vld_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/sd_blk_rx_ctrl.sv
module sd_blk_rx_ctrl
    import sd_blk_rx_pkg::*;
#(
    parameter int CW           = 16,
    parameter int NIBS         = 1024,
    parameter int TAIL_CLKS    = 17,
    parameter int TIMEOUT_CLKS = 65535
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sd_ce,
    input  logic          start,
    input  logic          multi,
    input  logic          dat0,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          pack_clr,
    output logic          pack_take,
    output logic          blk_done,
    output logic          timeout_flag
);
    localparam logic [CW-1:0] LAST_NIB  = CW'(NIBS - 1);
    localparam logic [CW-1:0] LAST_TAIL = CW'(TAIL_CLKS - 1);
    localparam logic [CW-1:0] LAST_POLL = CW'(TIMEOUT_CLKS - 1);

    rx_state_e state, state_nx;
    logic      done_nx, tmo_set, tmo_clr;

    always_comb begin
        state_nx  = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        pack_clr  = 1'b0;
        pack_take = 1'b0;
        done_nx   = 1'b0;
        tmo_set   = 1'b0;
        tmo_clr   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_HUNT;
                    cnt_clr  = 1'b1;
                    tmo_clr  = 1'b1;
                end
            end
            ST_HUNT: begin
                if (sd_ce) begin
                    if (!dat0) begin
                        state_nx = ST_DATA;
                        cnt_clr  = 1'b1;
                        pack_clr = 1'b1;
                    end else if (cnt == LAST_POLL) begin
                        state_nx = ST_IDLE;
                        tmo_set  = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (sd_ce) begin
                    pack_take = 1'b1;
                    if (cnt == LAST_NIB) begin
                        state_nx = ST_TAIL;
                        cnt_clr  = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (sd_ce) begin
                    if (cnt == LAST_TAIL) begin
                        state_nx = multi ? ST_HUNT : ST_IDLE;
                        cnt_clr  = 1'b1;
                        done_nx  = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_done     <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            blk_done <= done_nx;
            if (tmo_set)      timeout_flag <= 1'b1;
            else if (tmo_clr) timeout_flag <= 1'b0;
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R7
    tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> (state == ST_IDLE));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_ce && state != ST_IDLE) |=> (state == $past(state)));
endmodule

// File: rtl/sd_blk_rx.sv
module sd_blk_rx
    import sd_blk_rx_pkg::*;
#(
    parameter int BLOCK_BYTES  = 512,
    parameter int TAIL_CLKS    = 17,
    parameter int TIMEOUT_CLKS = 65535
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sd_ce,
    input  logic       start,
    input  logic       multi,
    input  logic [3:0] dat,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       blk_done,
    output logic       timeout_flag
);
    localparam int NIBS = 2 * BLOCK_BYTES;
    localparam int MAXC = max3(NIBS, TAIL_CLKS, TIMEOUT_CLKS);
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BW   = $clog2(BLOCK_BYTES + 1) + 1;

    logic [CW-1:0] cnt;
    logic          cnt_clr, cnt_inc, pack_clr, pack_take;

    sd_blk_rx_cnt #(.CW(CW)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    sd_blk_rx_ctrl #(
        .CW           (CW),
        .NIBS         (NIBS),
        .TAIL_CLKS    (TAIL_CLKS),
        .TIMEOUT_CLKS (TIMEOUT_CLKS)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sd_ce        (sd_ce),
        .start        (start),
        .multi        (multi),
        .dat0         (dat[0]),
        .cnt          (cnt),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .pack_clr     (pack_clr),
        .pack_take    (pack_take),
        .blk_done     (blk_done),
        .timeout_flag (timeout_flag)
    );

    sd_blk_rx_pack i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pack_clr),
        .take      (pack_take),
        .nib       (dat),
        .byte_vld  (byte_vld),
        .byte_data (byte_data)
    );

    logic [BW-1:0] bytes_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bytes_seen <= '0;
        else if (blk_done) bytes_seen <= '0;
        else if (byte_vld) bytes_seen <= bytes_seen + 1'b1;
    end

    // R5
    blk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (bytes_seen == BW'(BLOCK_BYTES)));

    // R7
    tmo_nobyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |-> !byte_vld);
endmodule

// File: tb/test_sd_blk_rx.sv
module test_sd_blk_rx;
    localparam int NB   = 4;
    localparam int TL   = 5;
    localparam int TMO  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sd_ce = 1'b0;
    logic       start = 1'b0;
    logic       multi = 1'b0;
    logic [3:0] dat = 4'hF;
    logic       byte_vld, blk_done, timeout_flag;
    logic [7:0] byte_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sd_blk_rx #(.BLOCK_BYTES(NB), .TAIL_CLKS(TL), .TIMEOUT_CLKS(TMO)) i_sd_blk_rx (
        .clk(clk), .rst_n(rst_n), .sd_ce(sd_ce), .start(start), .multi(multi),
        .dat(dat), .byte_vld(byte_vld), .byte_data(byte_data),
        .blk_done(blk_done), .timeout_flag(timeout_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input bit ce, input logic [3:0] d, input bit st);
        sd_ce = ce;
        dat   = d;
        start = st;
        @(negedge clk);
        start = 1'b0;
        sd_ce = 1'b0;
    endtask

    task automatic send_block(input int base, input int polls, input bit gap, input bit stray);
        for (int p = 0; p < polls; p++) begin
            tick(1'b1, 4'hF, 1'b0);
            chk(!byte_vld && !timeout_flag, "R3 hunt poll", {byte_vld, timeout_flag}, 0);
        end
        if (gap) begin
            tick(1'b0, 4'h0, 1'b0);
            chk(!byte_vld, "R9 no strobe in hunt", byte_vld, 0);
        end
        tick(1'b1, 4'hE, 1'b0);
        chk(!byte_vld, "R3 start bit not stored", byte_vld, 0);
        for (int i = 0; i < NB; i++) begin
            logic [7:0] b;
            b = 8'((base + i) & 255);
            tick(1'b1, b[7:4], stray && i == 1);
            chk(!byte_vld, "R4 high nibble", byte_vld, 0);
            if (gap) begin
                tick(1'b0, ~b[3:0], 1'b0);
                chk(!byte_vld, "R9 no strobe in data", byte_vld, 0);
            end
            tick(1'b1, b[3:0], 1'b0);
            chk(byte_vld && byte_data == b, "R4 byte value", {byte_vld, byte_data}, {1'b1, b});
        end
        for (int t = 0; t < TL; t++) begin
            tick(1'b1, 4'((t * 5) & 15), 1'b0);
            if (gap && t == 1) begin
                tick(1'b0, 4'h0, 1'b0);
                chk(!blk_done, "R9 no strobe in tail", blk_done, 0);
            end
            chk(!byte_vld, "R6 tail ignored", byte_vld, 0);
            chk(blk_done == (t == TL - 1), "R6 done timing", blk_done, (t == TL - 1));
        end
        tick(1'b0, 4'hF, 1'b0);
        chk(!blk_done, "R6 done one cycle", blk_done, 0);
    endtask

    task automatic expect_quiet(input string req);
        int nv;
        nv = 0;
        for (int i = 0; i < 3 * NB + TL + 2; i++) begin
            tick(1'b1, 4'((i & 1) ? 4'h0 : 4'h6), 1'b0);
            if (byte_vld || blk_done) nv++;
        end
        chk(nv == 0, req, nv, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(!byte_vld && !blk_done && !timeout_flag, "R1 reset outputs",
            {byte_vld, blk_done, timeout_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_quiet("R2 idle ignores DAT without start");

        multi = 1'b1;
        tick(1'b1, 4'hF, 1'b1);
        for (int k = 0; k < 64; k++) begin
            send_block(4 * k, k % 5, (k % 3) == 1, 1'b0);
        end
        chk(1'b1, "R8 multi rearm (64 blocks without start)", 1, 1);

        multi = 1'b0;
        send_block(8'h3C, 2, 1'b0, 1'b1);
        expect_quiet("R8 idle after block with multi low; R2 stray start ignored");

        tick(1'b1, 4'hF, 1'b1);
        for (int p = 0; p < TMO - 1; p++) begin
            tick(1'b1, 4'hF, 1'b0);
            chk(!timeout_flag, "R7 no early timeout", timeout_flag, 0);
        end
        tick(1'b1, 4'hF, 1'b0);
        chk(timeout_flag && !byte_vld, "R7 timeout on last poll", {timeout_flag, byte_vld}, 2);
        expect_quiet("R7 idle after timeout");
        chk(timeout_flag, "R7 flag sticky", timeout_flag, 1);
        tick(1'b0, 4'hF, 1'b1);
        chk(!timeout_flag, "R7 start clears flag", timeout_flag, 1'b0);
        send_block(8'h5A, TMO - 1, 1'b0, 1'b0);
        chk(!timeout_flag, "R7 start bit at window edge accepted", timeout_flag, 0);

        finish_run();
    end
endmodule